// File: doc/BRIEF.md
# Low-Speed USB IN Endpoint Transmit Handshake

This block arbitrates ownership of the transmit buffers of a low-speed USB device that serves IN transfers on endpoints 0, 1 and 2 at a single 7-bit bus address. For each endpoint, firmware writes up to eight payload bytes and a byte count, then arms the buffer. From that point the serial engine owns the buffer until the host acknowledges the packet. Only the engine can hand the buffer back, so firmware never overwrites data that is still in flight.

Token and handshake decoding sit outside the block and arrive as single-cycle strobes. An IN token addressed to the device is answered in one of three ways. A stalled endpoint gets STALL. An endpoint whose buffer is not armed gets NAK, and that endpoint's NAK event flag is set. An armed endpoint gets a DATA0 or DATA1 packet carrying its bytes. A host ACK releases the buffer and advances the endpoint's data toggle. A timeout leaves the buffer armed, so the same packet is sent again on the next IN token. The NAK event flags are ORed into one interrupt line.

Top module: `usb_in_ep_ctrl`

## Requirements
- R1: After reset every full flag, data toggle and NAK flag is 0, and resp_valid_o, tx_valid_o and irq_o are low.
- R2: An accepted IN token to a non-stalled endpoint whose buffer is not armed gives a response one cycle later with resp_kind_o = 0 (NAK) and sets that endpoint's bit in nak_flag_o; no data bytes follow.
- R3: A NAK-flag write clears each flag whose written bit is 0 and leaves each flag whose written bit is 1 unchanged; irq_o is high exactly while any NAK flag is set.
- R4: An IN token to an armed, non-stalled endpoint gives resp_kind_o = 2 (DATA0) when its toggle is 0 and 3 (DATA1) when its toggle is 1, with resp_len_o equal to the stored count; the bytes then appear on tx_data_o with tx_valid_o high, one per cycle in index order, starting in the cycle of the response.
- R5: A host ACK after a data packet clears that endpoint's full flag and inverts its toggle, both visible one cycle after the strobe.
- R6: A host timeout after a data packet leaves the full flag and toggle unchanged, and the next IN token resends the same bytes with the same PID.
- R7: Byte and count writes to an endpoint whose buffer is armed are ignored.
- R8: An endpoint whose stall input is high is answered with resp_kind_o = 1 (STALL) whether or not it is armed; its NAK flag and full flag are not changed.
- R9: A count of 0 sends a zero-length data packet with no data cycles; a written count above 8 is stored as 8.
- R10: IN tokens whose address differs from dev_addr_i, or whose endpoint number is 3, produce no response and set no flag.
- R11: A setup strobe addressed to the device on endpoint 0 resets the endpoint 0 toggle to 0.
- R12: A bus reset clears every full flag, toggle and NAK flag, and aborts a pending transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_reset_i | input | 1 | USB bus reset detected, one-cycle strobe |
| dev_addr_i | input | 7 | Assigned device address |
| stall_i | input | 3 | Per-endpoint stall control |
| fw_ep_i | input | 2 | Endpoint selected by firmware writes |
| fw_data_we_i | input | 1 | Firmware byte write strobe |
| fw_idx_i | input | 3 | Byte index within the buffer |
| fw_data_i | input | 8 | Byte to write |
| fw_cnt_we_i | input | 1 | Firmware count write strobe |
| fw_cnt_i | input | 4 | Byte count to write |
| fw_arm_i | input | 1 | Set the selected endpoint's full flag |
| fw_nak_we_i | input | 1 | NAK flag write strobe |
| fw_nak_wdata_i | input | 3 | NAK flag write data (0 clears, 1 keeps) |
| tok_in_i | input | 1 | IN token received strobe |
| setup_i | input | 1 | SETUP token received strobe |
| tok_addr_i | input | 7 | Address field of the token |
| tok_ep_i | input | 2 | Endpoint field of the token |
| host_ack_i | input | 1 | Host ACK handshake received strobe |
| host_timeout_i | input | 1 | No handshake within the response window |
| resp_valid_o | output | 1 | Response issued this cycle |
| resp_kind_o | output | 2 | 0 NAK, 1 STALL, 2 DATA0, 3 DATA1 |
| resp_len_o | output | 4 | Payload length of a data response |
| tx_valid_o | output | 1 | Payload byte valid |
| tx_data_o | output | 8 | Payload byte |
| full_o | output | 3 | Per-endpoint full flags |
| toggle_o | output | 3 | Per-endpoint data toggles |
| nak_flag_o | output | 3 | Per-endpoint NAK event flags |
| irq_o | output | 1 | Interrupt, any NAK flag set |

## Verification
IN tokens are sent to an empty endpoint, an armed one, a stalled one and an endpoint that is both stalled and armed. This shows that the choice among NAK, STALL and data depends only on the stall bit and the full flag. Back-to-back transfers on one endpoint check that the toggle alternates. A timeout followed by a repeat token, with rejected firmware writes in between, shows that the resend carries the original payload. Zero, full-size and over-range counts check the length handling, and foreign addresses and endpoint 3 check the token filter.

// File: rtl/usb_in_pkg.sv
package usb_in_pkg;
  localparam int NUM_EP  = 3;
  localparam int MAX_LEN = 8;
  localparam int ADDR_W  = 7;
  localparam int DATA_W  = 8;
  localparam int EP_W    = $clog2(NUM_EP + 1);
  localparam int IDX_W   = $clog2(MAX_LEN);
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  typedef enum logic [1:0] {
    RESP_NAK   = 2'd0,
    RESP_STALL = 2'd1,
    RESP_DATA0 = 2'd2,
    RESP_DATA1 = 2'd3
  } resp_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_WAIT = 2'd2
  } tx_st_e;
endpackage

// File: rtl/usb_in_ep_buf.sv
module usb_in_ep_buf
  import usb_in_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_reset_i,
  input  logic              wr_byte_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_val_i,
  input  logic              wr_cnt_i,
  input  logic [CNT_W-1:0]  cnt_val_i,
  input  logic              arm_i,
  input  logic              nak_set_i,
  input  logic              nak_clr_i,
  input  logic              ack_i,
  input  logic              tog_clr_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_byte_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              full_o,
  output logic              toggle_o,
  output logic              nak_o
);
  logic [DATA_W-1:0] mem_q [MAX_LEN];
  logic [CNT_W-1:0]  cnt_q, cnt_lim;
  logic              full_q, tog_q, nak_q;

  // firmware owns the buffer only while it is not armed
  always_ff @(posedge clk_i) begin
    if (wr_byte_i && !full_q) mem_q[wr_idx_i] <= wr_val_i;
  end

  assign cnt_lim = (cnt_val_i > CNT_W'(MAX_LEN)) ? CNT_W'(MAX_LEN) : cnt_val_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      full_q <= 1'b0;
      tog_q  <= 1'b0;
      nak_q  <= 1'b0;
    end else if (bus_reset_i) begin
      full_q <= 1'b0;
      tog_q  <= 1'b0;
      nak_q  <= 1'b0;
    end else begin
      if (wr_cnt_i && !full_q) cnt_q <= cnt_lim;
      if (ack_i)               full_q <= 1'b0;
      else if (arm_i)          full_q <= 1'b1;
      if (tog_clr_i)           tog_q <= 1'b0;
      else if (ack_i)          tog_q <= ~tog_q;
      if (nak_set_i)           nak_q <= 1'b1;
      else if (nak_clr_i)      nak_q <= 1'b0;
    end
  end

  assign rd_byte_o = mem_q[rd_idx_i];
  assign cnt_o     = cnt_q;
  assign full_o    = full_q;
  assign toggle_o  = tog_q;
  assign nak_o     = nak_q;
endmodule

// File: rtl/usb_in_tx_ctrl.sv
module usb_in_tx_ctrl
  import usb_in_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    bus_reset_i,
  input  logic [ADDR_W-1:0]       dev_addr_i,
  input  logic                    tok_in_i,
  input  logic                    setup_i,
  input  logic [ADDR_W-1:0]       tok_addr_i,
  input  logic [EP_W-1:0]         tok_ep_i,
  input  logic                    host_ack_i,
  input  logic                    host_timeout_i,
  input  logic [NUM_EP-1:0]       full_i,
  input  logic [NUM_EP-1:0]       stall_i,
  input  logic [NUM_EP-1:0]       toggle_i,
  input  logic [NUM_EP*CNT_W-1:0] cnt_i,
  output logic                    resp_valid_o,
  output logic [1:0]              resp_kind_o,
  output logic [CNT_W-1:0]        resp_len_o,
  output logic                    tx_valid_o,
  output logic [IDX_W-1:0]        rd_idx_o,
  output logic [EP_W-1:0]         cur_ep_o,
  output logic [NUM_EP-1:0]       nak_set_o,
  output logic [NUM_EP-1:0]       ack_o,
  output logic                    tog_clr0_o
);
  tx_st_e           st_q;
  resp_e            kind_q, kind_d;
  logic             rv_q;
  logic [CNT_W-1:0] len_q, cnt_sel;
  logic [IDX_W-1:0] idx_q;
  logic [EP_W-1:0]  ep_q;
  logic             addr_hit, ep_ok, accept;
  logic             sel_full, sel_stall, sel_tog;

  assign addr_hit = (tok_addr_i == dev_addr_i);
  assign ep_ok    = (int'(tok_ep_i) < NUM_EP);
  assign accept   = tok_in_i && addr_hit && ep_ok && (st_q == ST_IDLE) && !bus_reset_i;

  always_comb begin
    sel_full  = 1'b0;
    sel_stall = 1'b0;
    sel_tog   = 1'b0;
    cnt_sel   = '0;
    for (int k = 0; k < NUM_EP; k++) begin
      if (int'(tok_ep_i) == k) begin
        sel_full  = full_i[k];
        sel_stall = stall_i[k];
        sel_tog   = toggle_i[k];
        cnt_sel   = cnt_i[k*CNT_W +: CNT_W];
      end
    end
    if (sel_stall)     kind_d = RESP_STALL;
    else if (!sel_full) kind_d = RESP_NAK;
    else               kind_d = sel_tog ? RESP_DATA1 : RESP_DATA0;
  end

  for (genvar k = 0; k < NUM_EP; k++) begin : g_ev
    assign nak_set_o[k] = accept && (int'(tok_ep_i) == k) && !stall_i[k] && !full_i[k];
    assign ack_o[k]     = (st_q == ST_WAIT) && host_ack_i && (int'(ep_q) == k) && !bus_reset_i;
  end

  assign tog_clr0_o = setup_i && addr_hit && (tok_ep_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      rv_q   <= 1'b0;
      kind_q <= RESP_NAK;
      len_q  <= '0;
      idx_q  <= '0;
      ep_q   <= '0;
    end else if (bus_reset_i) begin
      st_q <= ST_IDLE;
      rv_q <= 1'b0;
    end else begin
      rv_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (accept) begin
          rv_q   <= 1'b1;
          kind_q <= kind_d;
          ep_q   <= tok_ep_i;
          idx_q  <= '0;
          if (kind_d == RESP_DATA0 || kind_d == RESP_DATA1) begin
            len_q <= cnt_sel;
            st_q  <= (cnt_sel == '0) ? ST_WAIT : ST_SEND;
          end else begin
            len_q <= '0;
          end
        end
        ST_SEND: begin
          idx_q <= idx_q + 1'b1;
          if (CNT_W'(idx_q) + 1'b1 == len_q) st_q <= ST_WAIT;
        end
        ST_WAIT: if (host_ack_i || host_timeout_i) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign resp_valid_o = rv_q;
  assign resp_kind_o  = kind_q;
  assign resp_len_o   = len_q;
  assign tx_valid_o   = (st_q == ST_SEND);
  assign rd_idx_o     = idx_q;
  assign cur_ep_o     = ep_q;
endmodule

// File: rtl/usb_in_ep_ctrl.sv
module usb_in_ep_ctrl
  import usb_in_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 bus_reset_i,
  input  logic [ADDR_W-1:0]    dev_addr_i,
  input  logic [NUM_EP-1:0]    stall_i,
  input  logic [EP_W-1:0]      fw_ep_i,
  input  logic                 fw_data_we_i,
  input  logic [IDX_W-1:0]     fw_idx_i,
  input  logic [DATA_W-1:0]    fw_data_i,
  input  logic                 fw_cnt_we_i,
  input  logic [CNT_W-1:0]     fw_cnt_i,
  input  logic                 fw_arm_i,
  input  logic                 fw_nak_we_i,
  input  logic [NUM_EP-1:0]    fw_nak_wdata_i,
  input  logic                 tok_in_i,
  input  logic                 setup_i,
  input  logic [ADDR_W-1:0]    tok_addr_i,
  input  logic [EP_W-1:0]      tok_ep_i,
  input  logic                 host_ack_i,
  input  logic                 host_timeout_i,
  output logic                 resp_valid_o,
  output logic [1:0]           resp_kind_o,
  output logic [CNT_W-1:0]     resp_len_o,
  output logic                 tx_valid_o,
  output logic [DATA_W-1:0]    tx_data_o,
  output logic [NUM_EP-1:0]    full_o,
  output logic [NUM_EP-1:0]    toggle_o,
  output logic [NUM_EP-1:0]    nak_flag_o,
  output logic                 irq_o
);
  logic [NUM_EP-1:0]       full, tog, nak, nak_set, ack;
  logic [NUM_EP*CNT_W-1:0] cnt_flat;
  logic [DATA_W-1:0]       rd_byte [NUM_EP];
  logic [IDX_W-1:0]        rd_idx;
  logic [EP_W-1:0]         cur_ep;
  logic                    tog_clr0;

  for (genvar k = 0; k < NUM_EP; k++) begin : g_ep
    logic sel;
    assign sel = (int'(fw_ep_i) == k);
    usb_in_ep_buf u_buf (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .bus_reset_i (bus_reset_i),
      .wr_byte_i   (fw_data_we_i && sel),
      .wr_idx_i    (fw_idx_i),
      .wr_val_i    (fw_data_i),
      .wr_cnt_i    (fw_cnt_we_i && sel),
      .cnt_val_i   (fw_cnt_i),
      .arm_i       (fw_arm_i && sel),
      .nak_set_i   (nak_set[k]),
      .nak_clr_i   (fw_nak_we_i && !fw_nak_wdata_i[k]),
      .ack_i       (ack[k]),
      .tog_clr_i   ((k == 0) && tog_clr0),
      .rd_idx_i    (rd_idx),
      .rd_byte_o   (rd_byte[k]),
      .cnt_o       (cnt_flat[k*CNT_W +: CNT_W]),
      .full_o      (full[k]),
      .toggle_o    (tog[k]),
      .nak_o       (nak[k])
    );
  end

  usb_in_tx_ctrl u_ctrl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .bus_reset_i    (bus_reset_i),
    .dev_addr_i     (dev_addr_i),
    .tok_in_i       (tok_in_i),
    .setup_i        (setup_i),
    .tok_addr_i     (tok_addr_i),
    .tok_ep_i       (tok_ep_i),
    .host_ack_i     (host_ack_i),
    .host_timeout_i (host_timeout_i),
    .full_i         (full),
    .stall_i        (stall_i),
    .toggle_i       (tog),
    .cnt_i          (cnt_flat),
    .resp_valid_o   (resp_valid_o),
    .resp_kind_o    (resp_kind_o),
    .resp_len_o     (resp_len_o),
    .tx_valid_o     (tx_valid_o),
    .rd_idx_o       (rd_idx),
    .cur_ep_o       (cur_ep),
    .nak_set_o      (nak_set),
    .ack_o          (ack),
    .tog_clr0_o     (tog_clr0)
  );

  always_comb begin
    tx_data_o = '0;
    for (int k = 0; k < NUM_EP; k++)
      if (int'(cur_ep) == k) tx_data_o = rd_byte[k];
  end

  assign full_o     = full;
  assign toggle_o   = tog;
  assign nak_flag_o = nak;
  assign irq_o      = |nak;
endmodule

// File: rtl/usb_in_ep_chk.sv
module usb_in_ep_chk
  import usb_in_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_reset_i,
  input logic              tok_in_i,
  input logic              host_ack_i,
  input logic              resp_valid_o,
  input logic [1:0]        resp_kind_o,
  input logic [NUM_EP-1:0] full_o,
  input logic [NUM_EP-1:0] nak_flag_o
);
  assert_nak_sets_flag_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && resp_kind_o == 2'd0) |-> (nak_flag_o != '0));

  assert_data_needs_full_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && resp_kind_o[1]) |-> (full_o != '0));

  assert_resp_from_token_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> $past(tok_in_i));

  assert_bus_reset_clears_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_reset_i |=> (full_o == '0 && nak_flag_o == '0 && !resp_valid_o));

  for (genvar k = 0; k < NUM_EP; k++) begin : g_p
    assert_full_release_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(full_o[k]) |-> $past(host_ack_i || bus_reset_i));
    assert_nak_rise_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(nak_flag_o[k]) |-> $past(tok_in_i));
  end
endmodule

bind usb_in_ep_ctrl usb_in_ep_chk chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .bus_reset_i  (bus_reset_i),
  .tok_in_i     (tok_in_i),
  .host_ack_i   (host_ack_i),
  .resp_valid_o (resp_valid_o),
  .resp_kind_o  (resp_kind_o),
  .full_o       (full_o),
  .nak_flag_o   (nak_flag_o)
);

// File: tb/usb_in_ep_ctrl_tb_top.sv
module usb_in_ep_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [6:0] DEV = 7'h2A;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       bus_reset = 0, fw_data_we = 0, fw_cnt_we = 0, fw_arm = 0, fw_nak_we = 0;
  logic       tok_in = 0, setup = 0, host_ack = 0, host_timeout = 0;
  logic [2:0] stall = 0, fw_nak_wdata = 0, fw_idx = 0;
  logic [1:0] fw_ep = 0, tok_ep = 0;
  logic [7:0] fw_data = 0;
  logic [3:0] fw_cnt = 0;
  logic [6:0] tok_addr = 0;
  logic       resp_valid, tx_valid, irq;
  logic [1:0] resp_kind;
  logic [3:0] resp_len;
  logic [7:0] tx_data;
  logic [2:0] full, toggle, nak_flag;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_in_ep_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_reset_i(bus_reset), .dev_addr_i(DEV),
    .stall_i(stall), .fw_ep_i(fw_ep), .fw_data_we_i(fw_data_we), .fw_idx_i(fw_idx),
    .fw_data_i(fw_data), .fw_cnt_we_i(fw_cnt_we), .fw_cnt_i(fw_cnt), .fw_arm_i(fw_arm),
    .fw_nak_we_i(fw_nak_we), .fw_nak_wdata_i(fw_nak_wdata), .tok_in_i(tok_in),
    .setup_i(setup), .tok_addr_i(tok_addr), .tok_ep_i(tok_ep), .host_ack_i(host_ack),
    .host_timeout_i(host_timeout), .resp_valid_o(resp_valid), .resp_kind_o(resp_kind),
    .resp_len_o(resp_len), .tx_valid_o(tx_valid), .tx_data_o(tx_data), .full_o(full),
    .toggle_o(toggle), .nak_flag_o(nak_flag), .irq_o(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_byte(logic [1:0] ep, logic [2:0] idx, logic [7:0] val);
    @(negedge clk); fw_ep = ep; fw_idx = idx; fw_data = val; fw_data_we = 1;
    @(negedge clk); fw_data_we = 0;
  endtask

  task automatic wr_cnt(logic [1:0] ep, logic [3:0] c);
    @(negedge clk); fw_ep = ep; fw_cnt = c; fw_cnt_we = 1;
    @(negedge clk); fw_cnt_we = 0;
  endtask

  task automatic arm(logic [1:0] ep);
    @(negedge clk); fw_ep = ep; fw_arm = 1;
    @(negedge clk); fw_arm = 0;
  endtask

  task automatic load(logic [1:0] ep, logic [7:0] seed, int n, logic [3:0] c);
    for (int i = 0; i < n; i++) wr_byte(ep, 3'(i), seed + 8'(i * 17));
    wr_cnt(ep, c);
    arm(ep);
  endtask

  // token strobe; returns at the negedge where the response is visible
  task automatic token(logic [6:0] addr, logic [1:0] ep);
    @(negedge clk); tok_addr = addr; tok_ep = ep; tok_in = 1;
    @(negedge clk); tok_in = 0;
  endtask

  task automatic expect_data(string req, logic [1:0] kind, int len, logic [7:0] seed);
    check({req, " resp_valid"}, resp_valid, 1);
    check({req, " kind"}, resp_kind, kind);
    check({req, " len"}, resp_len, len);
    for (int i = 0; i < len; i++) begin
      check({req, " tx_valid"}, tx_valid, 1);
      check({req, " tx_data"}, tx_data, seed + 8'(i * 17));
      @(negedge clk);
    end
    check({req, " tx_valid end"}, tx_valid, 0);
  endtask

  task automatic host_ack_pulse();
    @(negedge clk); host_ack = 1;
    @(negedge clk); host_ack = 0;
  endtask

  task automatic t_reset();
    check("R1 full", full, 0);
    check("R1 toggle", toggle, 0);
    check("R1 nak", nak_flag, 0);
    check("R1 resp_valid", resp_valid, 0);
    check("R1 tx_valid", tx_valid, 0);
    check("R1 irq", irq, 0);
  endtask

  task automatic t_nak();
    token(DEV, 2'd1);
    check("R2 resp_valid", resp_valid, 1);
    check("R2 kind NAK", resp_kind, 0);
    check("R2 nak flag", nak_flag, 3'b010);
    check("R2 no data", tx_valid, 0);
    check("R3 irq set", irq, 1);
    @(negedge clk); fw_nak_wdata = 3'b111; fw_nak_we = 1;
    @(negedge clk); fw_nak_we = 0;
    check("R3 write one keeps", nak_flag, 3'b010);
    @(negedge clk); fw_nak_wdata = 3'b101; fw_nak_we = 1;
    @(negedge clk); fw_nak_we = 0;
    check("R3 write zero clears", nak_flag, 0);
    check("R3 irq clear", irq, 0);
  endtask

  task automatic t_data();
    load(2'd1, 8'h11, 4, 4'd4);
    check("R4 armed", full[1], 1);
    token(DEV, 2'd1);
    expect_data("R4 DATA0", 2'd2, 4, 8'h11);
    check("R4 no nak", nak_flag, 0);
    host_ack_pulse();
    check("R5 full cleared", full[1], 0);
    check("R5 toggle flipped", toggle[1], 1);
    load(2'd1, 8'h50, 2, 4'd2);
    token(DEV, 2'd1);
    expect_data("R4 DATA1", 2'd3, 2, 8'h50);
    host_ack_pulse();
    check("R5 toggle back", toggle[1], 0);
  endtask

  task automatic t_timeout();
    load(2'd2, 8'hA1, 3, 4'd3);
    token(DEV, 2'd2);
    expect_data("R6 first", 2'd2, 3, 8'hA1);
    @(negedge clk); host_timeout = 1;
    @(negedge clk); host_timeout = 0;
    check("R6 full kept", full[2], 1);
    check("R6 toggle kept", toggle[2], 0);
    wr_byte(2'd2, 3'd0, 8'hFF);
    wr_cnt(2'd2, 4'd1);
    token(DEV, 2'd2);
    expect_data("R7 resend unchanged", 2'd2, 3, 8'hA1);
    host_ack_pulse();
    check("R5 ep2 released", full[2], 0);
  endtask

  task automatic t_stall_zero();
    stall = 3'b001;
    token(DEV, 2'd0);
    check("R8 stall empty", resp_kind, 1);
    check("R8 no nak", nak_flag, 0);
    wr_cnt(2'd0, 4'd0);
    arm(2'd0);
    token(DEV, 2'd0);
    check("R8 stall armed", resp_kind, 1);
    check("R8 full kept", full[0], 1);
    check("R8 no data", tx_valid, 0);
    stall = 3'b000;
    token(DEV, 2'd0);
    expect_data("R9 zero length", 2'd2, 0, 8'h00);
    host_ack_pulse();
    check("R9 zlp released", full[0], 0);
    check("R5 ep0 toggle", toggle[0], 1);
  endtask

  task automatic t_setup();
    @(negedge clk); tok_addr = DEV; tok_ep = 2'd0; setup = 1;
    @(negedge clk); setup = 0;
    check("R11 ep0 toggle reset", toggle[0], 0);
  endtask

  task automatic t_clamp();
    load(2'd2, 8'h03, 8, 4'd12);
    token(DEV, 2'd2);
    expect_data("R9 clamp to 8", 2'd3, 8, 8'h03);
    host_ack_pulse();
  endtask

  task automatic t_filter();
    token(DEV + 7'd1, 2'd1);
    check("R10 other address", resp_valid, 0);
    check("R10 other address nak", nak_flag, 0);
    token(DEV, 2'd3);
    check("R10 endpoint 3", resp_valid, 0);
    check("R10 endpoint 3 nak", nak_flag, 0);
  endtask

  task automatic t_bus_reset();
    load(2'd1, 8'h70, 1, 4'd1);
    token(DEV, 2'd1);
    expect_data("R12 prep", 2'd2, 1, 8'h70);
    host_ack_pulse();
    load(2'd0, 8'h01, 1, 4'd1);
    token(DEV, 2'd2);
    check("R12 prep nak", nak_flag, 3'b100);
    check("R12 prep toggle", toggle, 3'b010);
    @(negedge clk); bus_reset = 1;
    @(negedge clk); bus_reset = 0;
    check("R12 full", full, 0);
    check("R12 toggle", toggle, 0);
    check("R12 nak", nak_flag, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_nak();
    t_data();
    t_timeout();
    t_stall_zero();
    t_setup();
    t_clamp();
    t_filter();
    t_bus_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule